// File: doc/BRIEF.md
# Record Slot Map Manager

This block keeps the directory of a fixed-slot record store: one 64-bit record identifier per slot, held in a synchronous RAM, and a running count of the slots that hold a record. The store is split into equal slots. The header and the directory occupy the leading slots, so usable slots start at a first index (header size over slot size, rounded up) and stop one short of a last index (store size over slot size). An entry of zero means the slot is empty. An identifier of all ones means "end" or "nothing".

A host issues one request at a time. It raises `req_valid` while `req_ready` is high, and then waits for the one-cycle `rsp_done` pulse. The pulse carries a slot index, an identifier and a status byte. A slot index of 0 always means "none".

The requests cover several tasks. Lookup finds a record. Free-slot search finds an empty slot. Insert places a record and clear removes one. Two iteration requests, plain and restart-from-first, walk the records through a cursor that persists between requests. Read resolves the record a host wants to fetch. The directory is scanned at one entry per clock.

Top module: `slot_map_mgr`

## Requirements
- R1: After reset the block clears every directory entry, holds `req_ready` low until that is done, and then reports `rec_count` = 0. Any non-zero `rsp_idx` lies in [first index, last index).
- R2: Lookup (`req_op` = 0) returns the lowest slot whose entry equals the identifier, with status 0x00. An absent identifier, or an identifier of 0, returns slot 0 with status 0x05.
- R3: A lookup scan stops once it has passed as many occupied entries as `rec_count`. A missed lookup in a store holding one record near the front completes within 8 cycles of acceptance.
- R4: Free-slot search (`req_op` = 1) returns the lowest empty slot with status 0x00. A full store returns slot 0 with status 0x01.
- R5: Insert (`req_op` = 6) behaves as follows:
  - An identifier of 0 or all ones is rejected with status 0x03.
  - An identifier already present keeps its slot and leaves the count unchanged.
  - A new identifier takes the lowest empty slot and raises the count by one.
  - A full store gives slot 0 with status 0x01.
- R6: Clear (`req_op` = 2) behaves as follows:
  - An identifier of 0 or all ones is rejected with status 0x03.
  - An absent identifier gives status 0x05.
  - A present identifier has its entry zeroed and the count lowered by one, with status 0x00 and its slot returned.
- R7: Next (`req_op` = 3) behaves as follows:
  - With a count of 0 it returns all ones.
  - Otherwise it returns the first occupied entry at or after the cursor, with its slot, and moves the cursor to that slot plus one.
  - When nothing is left, it returns all ones and puts the cursor back to the first index.
  - Status is always 0x00.
- R8: Restart-next (`req_op` = 4) moves the cursor to the first index before scanning. Reset also puts the cursor at the first index.
- R9: Read (`req_op` = 5) behaves as follows:
  - With a count of 0 it returns status 0x04.
  - With an all-ones identifier it returns status 0x03.
  - With identifier 0 it resolves to the first stored record, returning its slot and identifier, and the cursor moves past that record.
  - With a present identifier it returns its slot with status 0x00.
- R10: A read of an absent identifier returns slot 0 and status 0x05. It restarts the iteration: `rsp_id` carries the first stored identifier, and the cursor moves past it.
- R11: `rsp_done` lasts exactly one cycle per accepted request. `req_ready` is low from acceptance until the response. Undefined op codes (7) return status 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_op | input | 3 | Request code (0 lookup, 1 free slot, 2 clear, 3 next, 4 restart-next, 5 read, 6 insert) |
| req_id | input | ID_W | Record identifier of the request |
| req_ready | output | 1 | Block idle and able to accept a request |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_idx | output | IW | Slot index of the response, 0 for none |
| rsp_id | output | ID_W | Identifier of the response |
| rsp_status | output | 8 | Status code (0x00 ok, 0x01 no space, 0x03 bad identifier, 0x04 store empty, 0x05 not found) |
| rec_count | output | IW | Number of occupied slots |

## Verification
Every cycle, the checker confirms the response handshake:
- the done pulse is one cycle wide;
- acceptance either answers at once or drops ready.

It also checks that returned slots stay inside the usable range, that the count never exceeds the number of usable slots, and that the count moves only with a response. It further ties the "no space", "not found" and "store empty" statuses to a zero slot or an empty store.

Other behaviours depend on history, and only the bench's request sequences against its own directory model can show them:
- lowest-slot placement;
- cursor resumption and wrap;
- read-miss restart;
- early stop of a lookup once the count is exhausted.

// File: rtl/slot_map_pkg.sv
// Shared types for the record slot map manager.
// Assumes: request and status codes are part of the host contract.
package slot_map_pkg;

    typedef enum logic [2:0] {
        OP_LOOKUP     = 3'd0,
        OP_FIND_FREE  = 3'd1,
        OP_CLEAR      = 3'd2,
        OP_NEXT       = 3'd3,
        OP_NEXT_FIRST = 3'd4,
        OP_READ       = 3'd5,
        OP_INSERT     = 3'd6
    } map_op_e;

    typedef enum logic [1:0] {
        SCAN_MATCH,
        SCAN_FREE,
        SCAN_USED
    } scan_mode_e;

    localparam logic [7:0] ST_OK          = 8'h00;
    localparam logic [7:0] ST_NO_SPACE    = 8'h01;
    localparam logic [7:0] ST_BAD_ID      = 8'h03;
    localparam logic [7:0] ST_STORE_EMPTY = 8'h04;
    localparam logic [7:0] ST_NOT_FOUND   = 8'h05;

endpackage

// File: rtl/slot_map_ram.sv
// Directory storage: one identifier per slot, one write port and one
// registered read port.
// Assumes: contents are undefined until the sequencer's clearing sweep; no
// read and write of the same address happen in the same cycle.
module slot_map_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 64
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store one entry when the write enable is high.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read: data appears the cycle after the address.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/slot_map_scan.sv
// Directory scanner.
// Walks slots upward from a start index to the last index, issuing one RAM
// read per cycle and testing each returned entry against the mode:
// - match a key;
// - find an empty entry;
// - find an occupied entry.
// Match scans also stop once they have passed as many occupied entries as
// the record count captured at start.
// Reports one finish pulse with hit flag, slot and entry.
// Assumes: start is only pulsed while idle; hit_idx is 0 on a miss.
module slot_map_scan
    import slot_map_pkg::*;
#(
    parameter int ID_W = 64,
    parameter int IW   = 5,
    parameter int AW   = 4,
    parameter int LAST = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  scan_mode_e      mode,
    input  logic [IW-1:0]   start_idx,
    input  logic [ID_W-1:0] key,
    input  logic [IW-1:0]   count,
    output logic [AW-1:0]   rd_addr,
    input  logic [ID_W-1:0] rd_data,
    output logic            fin,
    output logic            hit,
    output logic [IW-1:0]   hit_idx,
    output logic [ID_W-1:0] hit_data
);

    localparam logic [IW-1:0] LAST_I = IW'(LAST);

    logic            busy;
    logic [IW-1:0]   ptr;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   passed;
    logic [IW-1:0]   count_q;
    logic            vld_q;
    scan_mode_e      mode_q;
    logic [ID_W-1:0] key_q;

    logic occupied, match, hit_now, exhaust, finish, issue;

    // Evaluate the entry returned for the previous cycle's address.
    always_comb begin
        occupied = (rd_data != '0);
        unique case (mode_q)
            SCAN_MATCH: match = (rd_data == key_q);
            SCAN_FREE:  match = !occupied;
            default:    match = occupied;
        endcase
        hit_now = vld_q && match;
        exhaust = vld_q && (mode_q == SCAN_MATCH) && !match && occupied &&
                  ((passed + IW'(1)) >= count_q);
        finish  = busy && (hit_now || exhaust || (!vld_q && (ptr >= LAST_I)));
        issue   = busy && !finish && (ptr < LAST_I);
        rd_addr = ptr[AW-1:0];
    end

    // Scan pointer, pipeline tag and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            ptr      <= '0;
            idx_q    <= '0;
            passed   <= '0;
            count_q  <= '0;
            vld_q    <= 1'b0;
            mode_q   <= SCAN_MATCH;
            key_q    <= '0;
            fin      <= 1'b0;
            hit      <= 1'b0;
            hit_idx  <= '0;
            hit_data <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                ptr     <= start_idx;
                vld_q   <= 1'b0;
                passed  <= '0;
                count_q <= count;
                mode_q  <= mode;
                key_q   <= key;
            end else if (busy) begin
                vld_q <= issue;
                idx_q <= ptr;
                if (issue) begin
                    ptr <= ptr + IW'(1);
                end
                if (vld_q && occupied) begin
                    passed <= passed + IW'(1);
                end
                if (finish) begin
                    busy     <= 1'b0;
                    vld_q    <= 1'b0;
                    fin      <= 1'b1;
                    hit      <= hit_now;
                    hit_idx  <= hit_now ? idx_q : '0;
                    hit_data <= rd_data;
                end
            end
        end
    end

endmodule

// File: rtl/slot_map_seq.sv
// Request sequencer.
// Clears the directory after reset, decodes each request, and chains the
// scans a request needs. It also:
// - writes directory updates;
// - keeps the record count and the iteration cursor;
// - produces the one-cycle response.
// Assumes: one request in flight; the scanner reports exactly one finish
// per start.
module slot_map_seq
    import slot_map_pkg::*;
#(
    parameter int ID_W     = 64,
    parameter int IW       = 5,
    parameter int AW       = 4,
    parameter int SLOT_CNT = 16,
    parameter int FIRST    = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [ID_W-1:0] req_id,
    output logic            ready,
    output logic            done,
    output logic [IW-1:0]   rsp_idx,
    output logic [ID_W-1:0] rsp_id,
    output logic [7:0]      rsp_status,
    output logic [IW-1:0]   count,
    output logic            scan_start,
    output scan_mode_e      scan_mode,
    output logic [IW-1:0]   scan_from,
    output logic [ID_W-1:0] scan_key,
    input  logic            scan_fin,
    input  logic            scan_hit,
    input  logic [IW-1:0]   scan_idx,
    input  logic [ID_W-1:0] scan_data,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [ID_W-1:0] wr_data
);

    localparam logic [IW-1:0] FIRST_I   = IW'(FIRST);
    localparam logic [AW-1:0] LAST_ADDR = AW'(SLOT_CNT - 1);
    localparam logic [ID_W-1:0] ONES    = '1;

    typedef enum logic [3:0] {
        S_INIT, S_IDLE, S_LOOK, S_FREE, S_CLR, S_NEXT,
        S_RD_FIRST, S_RD_LOOK, S_RD_MISS, S_INS_LOOK, S_INS_NEW
    } seq_state_e;

    seq_state_e      state, state_n;
    logic [AW-1:0]   init_ptr;
    logic [IW-1:0]   cursor;
    logic [ID_W-1:0] key_q;

    logic            rsp_en, go, cur_en, cnt_inc, cnt_dec, wr_n, key_ld;
    logic [IW-1:0]   rsp_idx_n, go_from, cur_n;
    logic [ID_W-1:0] rsp_id_n, wr_data_n;
    logic [7:0]      rsp_st_n;
    logic [AW-1:0]   wr_addr_n;
    scan_mode_e      go_mode;
    logic            id_ok;

    assign ready    = (state == S_IDLE) && !done;
    assign scan_key = key_q;
    assign id_ok    = (req_id != '0) && (req_id != ONES);

    // Next-state, response and side-effect decisions.
    always_comb begin
        state_n   = state;
        rsp_en    = 1'b0;
        rsp_idx_n = '0;
        rsp_id_n  = key_q;
        rsp_st_n  = ST_OK;
        go        = 1'b0;
        go_mode   = SCAN_MATCH;
        go_from   = FIRST_I;
        cur_en    = 1'b0;
        cur_n     = FIRST_I;
        cnt_inc   = 1'b0;
        cnt_dec   = 1'b0;
        wr_n      = 1'b0;
        wr_addr_n = '0;
        wr_data_n = '0;
        key_ld    = 1'b0;
        unique case (state)
            S_INIT: begin
                wr_n      = 1'b1;
                wr_addr_n = init_ptr;
                if (init_ptr == LAST_ADDR) state_n = S_IDLE;
            end
            S_IDLE: begin
                rsp_id_n = req_id;
                if (ready && req_valid) begin
                    key_ld = 1'b1;
                    case (map_op_e'(req_op))
                        OP_LOOKUP: begin
                            if (req_id == '0 || count == '0) begin
                                rsp_en   = 1'b1;
                                rsp_st_n = ST_NOT_FOUND;
                            end else begin
                                go = 1'b1; state_n = S_LOOK;
                            end
                        end
                        OP_FIND_FREE: begin
                            go = 1'b1; go_mode = SCAN_FREE; state_n = S_FREE;
                        end
                        OP_CLEAR: begin
                            if (!id_ok) begin
                                rsp_en = 1'b1; rsp_st_n = ST_BAD_ID;
                            end else if (count == '0) begin
                                rsp_en = 1'b1; rsp_st_n = ST_NOT_FOUND;
                            end else begin
                                go = 1'b1; state_n = S_CLR;
                            end
                        end
                        OP_NEXT, OP_NEXT_FIRST: begin
                            if (count == '0) begin
                                rsp_en   = 1'b1;
                                rsp_id_n = ONES;
                                cur_en   = 1'b1;
                            end else begin
                                go      = 1'b1;
                                go_mode = SCAN_USED;
                                go_from = (map_op_e'(req_op) == OP_NEXT_FIRST) ? FIRST_I : cursor;
                                state_n = S_NEXT;
                            end
                        end
                        OP_READ: begin
                            if (count == '0) begin
                                rsp_en = 1'b1; rsp_st_n = ST_STORE_EMPTY;
                            end else if (req_id == '0) begin
                                go = 1'b1; go_mode = SCAN_USED; state_n = S_RD_FIRST;
                            end else if (req_id == ONES) begin
                                rsp_en = 1'b1; rsp_st_n = ST_BAD_ID;
                            end else begin
                                go = 1'b1; state_n = S_RD_LOOK;
                            end
                        end
                        OP_INSERT: begin
                            if (!id_ok) begin
                                rsp_en = 1'b1; rsp_st_n = ST_BAD_ID;
                            end else if (count == '0) begin
                                go = 1'b1; go_mode = SCAN_FREE; state_n = S_INS_NEW;
                            end else begin
                                go = 1'b1; state_n = S_INS_LOOK;
                            end
                        end
                        default: begin
                            rsp_en = 1'b1; rsp_st_n = ST_BAD_ID;
                        end
                    endcase
                end
            end
            S_LOOK: if (scan_fin) begin
                rsp_en = 1'b1; state_n = S_IDLE;
                rsp_idx_n = scan_idx;
                rsp_st_n  = scan_hit ? ST_OK : ST_NOT_FOUND;
            end
            S_FREE: if (scan_fin) begin
                rsp_en = 1'b1; state_n = S_IDLE;
                rsp_idx_n = scan_idx;
                rsp_id_n  = '0;
                rsp_st_n  = scan_hit ? ST_OK : ST_NO_SPACE;
            end
            S_CLR: if (scan_fin) begin
                rsp_en = 1'b1; state_n = S_IDLE;
                rsp_idx_n = scan_idx;
                rsp_st_n  = scan_hit ? ST_OK : ST_NOT_FOUND;
                wr_n      = scan_hit;
                wr_addr_n = scan_idx[AW-1:0];
                cnt_dec   = scan_hit;
            end
            S_NEXT, S_RD_FIRST, S_RD_MISS: if (scan_fin) begin
                rsp_en = 1'b1; state_n = S_IDLE;
                cur_en = 1'b1;
                cur_n  = scan_hit ? scan_idx + IW'(1) : FIRST_I;
                rsp_id_n  = scan_hit ? scan_data : ONES;
                rsp_idx_n = (state == S_RD_MISS) ? '0 : scan_idx;
                if (state == S_RD_MISS)       rsp_st_n = ST_NOT_FOUND;
                else if (state == S_RD_FIRST) rsp_st_n = scan_hit ? ST_OK : ST_BAD_ID;
            end
            S_RD_LOOK: if (scan_fin) begin
                if (scan_hit) begin
                    rsp_en = 1'b1; state_n = S_IDLE;
                    rsp_idx_n = scan_idx;
                end else begin
                    go = 1'b1; go_mode = SCAN_USED; state_n = S_RD_MISS;
                end
            end
            S_INS_LOOK: if (scan_fin) begin
                if (scan_hit) begin
                    rsp_en = 1'b1; state_n = S_IDLE;
                    rsp_idx_n = scan_idx;
                    wr_n      = 1'b1;
                    wr_addr_n = scan_idx[AW-1:0];
                    wr_data_n = key_q;
                end else begin
                    go = 1'b1; go_mode = SCAN_FREE; state_n = S_INS_NEW;
                end
            end
            S_INS_NEW: if (scan_fin) begin
                rsp_en = 1'b1; state_n = S_IDLE;
                rsp_idx_n = scan_idx;
                rsp_st_n  = scan_hit ? ST_OK : ST_NO_SPACE;
                wr_n      = scan_hit;
                wr_addr_n = scan_idx[AW-1:0];
                wr_data_n = key_q;
                cnt_inc   = scan_hit;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // State, counters, cursor and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_INIT;
            init_ptr   <= '0;
            cursor     <= FIRST_I;
            count      <= '0;
            key_q      <= '0;
            done       <= 1'b0;
            rsp_idx    <= '0;
            rsp_id     <= '0;
            rsp_status <= ST_OK;
            scan_start <= 1'b0;
            scan_mode  <= SCAN_MATCH;
            scan_from  <= FIRST_I;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            state      <= state_n;
            done       <= rsp_en;
            scan_start <= go;
            wr_en      <= wr_n;
            wr_addr    <= wr_addr_n;
            wr_data    <= wr_data_n;
            if (state == S_INIT) init_ptr <= init_ptr + AW'(1);
            if (key_ld) key_q <= req_id;
            if (rsp_en) begin
                rsp_idx    <= rsp_idx_n;
                rsp_id     <= rsp_id_n;
                rsp_status <= rsp_st_n;
            end
            if (go) begin
                scan_mode <= go_mode;
                scan_from <= go_from;
            end
            if (cur_en) cursor <= cur_n;
            if (cnt_inc)      count <= count + IW'(1);
            else if (cnt_dec) count <= count - IW'(1);
        end
    end

endmodule

// File: rtl/slot_map_mgr.sv
// Record slot map manager top.
// Geometry comes from byte sizes:
// - usable slots start at the header size over the slot size, rounded up;
// - usable slots end before the store size over the slot size.
// Assumes: STORE_BYTES is a multiple of SLOT_BYTES and leaves at least one
// usable slot.
module slot_map_mgr
    import slot_map_pkg::*;
#(
    parameter int ID_W        = 64,
    parameter int STORE_BYTES = 65536,
    parameter int SLOT_BYTES  = 4096,
    parameter int HDR_BYTES   = 4096,
    localparam int SLOT_CNT   = STORE_BYTES / SLOT_BYTES,
    localparam int FIRST_SLOT = (HDR_BYTES + SLOT_BYTES - 1) / SLOT_BYTES,
    localparam int IW         = $clog2(SLOT_CNT + 1),
    localparam int AW         = $clog2(SLOT_CNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [ID_W-1:0] req_id,
    output logic            req_ready,
    output logic            rsp_done,
    output logic [IW-1:0]   rsp_idx,
    output logic [ID_W-1:0] rsp_id,
    output logic [7:0]      rsp_status,
    output logic [IW-1:0]   rec_count
);

    logic            scan_start, scan_fin, scan_hit, wr_en;
    scan_mode_e      scan_mode;
    logic [IW-1:0]   scan_from, scan_idx;
    logic [ID_W-1:0] scan_key, scan_data, wr_data, rd_data;
    logic [AW-1:0]   wr_addr, rd_addr;

    slot_map_ram #(.DEPTH(SLOT_CNT), .AW(AW), .DW(ID_W)) i_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    slot_map_scan #(.ID_W(ID_W), .IW(IW), .AW(AW), .LAST(SLOT_CNT)) i_scan (
        .clk(clk), .rst_n(rst_n), .start(scan_start), .mode(scan_mode),
        .start_idx(scan_from), .key(scan_key), .count(rec_count),
        .rd_addr(rd_addr), .rd_data(rd_data), .fin(scan_fin), .hit(scan_hit),
        .hit_idx(scan_idx), .hit_data(scan_data)
    );

    slot_map_seq #(.ID_W(ID_W), .IW(IW), .AW(AW), .SLOT_CNT(SLOT_CNT),
                   .FIRST(FIRST_SLOT)) i_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_id(req_id), .ready(req_ready), .done(rsp_done), .rsp_idx(rsp_idx),
        .rsp_id(rsp_id), .rsp_status(rsp_status), .count(rec_count),
        .scan_start(scan_start), .scan_mode(scan_mode), .scan_from(scan_from),
        .scan_key(scan_key), .scan_fin(scan_fin), .scan_hit(scan_hit),
        .scan_idx(scan_idx), .scan_data(scan_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

endmodule

// File: rtl/slot_map_chk.sv
// Protocol and range checks for slot_map_mgr, attached by bind.
// Assumes: same geometry parameters as the bound top.
module slot_map_chk
    import slot_map_pkg::*;
#(
    parameter int STORE_BYTES = 65536,
    parameter int SLOT_BYTES  = 4096,
    parameter int HDR_BYTES   = 4096,
    localparam int SLOT_CNT   = STORE_BYTES / SLOT_BYTES,
    localparam int FIRST_SLOT = (HDR_BYTES + SLOT_BYTES - 1) / SLOT_BYTES,
    localparam int IW         = $clog2(SLOT_CNT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_done,
    input logic [IW-1:0] rsp_idx,
    input logic [7:0]    rsp_status,
    input logic [IW-1:0] rec_count
);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_done || !req_ready));

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_idx != '0) |->
            (rsp_idx >= IW'(FIRST_SLOT) && rsp_idx < IW'(SLOT_CNT)));

    // R1
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_count <= IW'(SLOT_CNT - FIRST_SLOT));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rec_count) |-> rsp_done);

    // R4
    no_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_status == ST_NO_SPACE) |-> rsp_idx == '0);

    // R6
    not_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_status == ST_NOT_FOUND) |-> rsp_idx == '0);

    // R9
    store_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_status == ST_STORE_EMPTY) |-> rec_count == '0);

endmodule

bind slot_map_mgr slot_map_chk #(
    .STORE_BYTES(STORE_BYTES), .SLOT_BYTES(SLOT_BYTES), .HDR_BYTES(HDR_BYTES)
) i_slot_map_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_idx(rsp_idx), .rsp_status(rsp_status),
    .rec_count(rec_count)
);

// File: tb/test_slot_map_mgr.sv
`timescale 1ns/1ps
module test_slot_map_mgr;

    localparam int FIRST = 1;
    localparam int LAST  = 16;
    localparam int IW    = 5;
    localparam logic [63:0] ONES = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = '0;
    logic [63:0]     req_id = '0;
    logic            req_ready, rsp_done;
    logic [IW-1:0]   rsp_idx, rec_count;
    logic [63:0]     rsp_id;
    logic [7:0]      rsp_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    logic [63:0] m_map [LAST];
    int          m_cnt;
    int          m_cur;

    always #2 clk = ~clk;

    slot_map_mgr i_slot_map_mgr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_id(req_id), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_idx(rsp_idx), .rsp_id(rsp_id), .rsp_status(rsp_status),
        .rec_count(rec_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_find(input logic [63:0] id);
        for (int i = FIRST; i < LAST; i++) if (m_map[i] == id) return i;
        return 0;
    endfunction

    function automatic int m_used(input int b);
        for (int i = b; i < LAST; i++) if (m_map[i] != 0) return i;
        return 0;
    endfunction

    // Expected response per the requirements; updates the reference directory.
    task automatic model(input int op, input logic [63:0] id, output int e_idx,
                         output logic [63:0] e_id, output int e_st, output bit c_id);
        int i, j;
        e_idx = 0; e_id = id; e_st = 0; c_id = 1;
        case (op)
            0: begin
                i = (id == 0 || m_cnt == 0) ? 0 : m_find(id);
                e_idx = i; e_st = i != 0 ? 0 : 5;
            end
            1: begin
                i = m_find(0); e_idx = i; e_st = i != 0 ? 0 : 1; c_id = 0;
            end
            2: begin
                if (id == 0 || id == ONES) e_st = 3;
                else begin
                    i = (m_cnt != 0) ? m_find(id) : 0;
                    if (i != 0) begin m_map[i] = 0; m_cnt--; e_idx = i; end
                    else e_st = 5;
                end
            end
            3, 4: begin
                j = (op == 4) ? FIRST : m_cur;
                i = (m_cnt == 0) ? 0 : m_used(j);
                if (i != 0) begin m_cur = i + 1; e_idx = i; e_id = m_map[i]; end
                else begin m_cur = FIRST; e_id = ONES; end
            end
            5: begin
                if (m_cnt == 0) e_st = 4;
                else if (id == 0) begin
                    i = m_used(FIRST);
                    if (i != 0) begin m_cur = i + 1; e_idx = i; e_id = m_map[i]; end
                    else begin m_cur = FIRST; e_id = ONES; e_st = 3; end
                end else if (id == ONES) e_st = 3;
                else begin
                    i = m_find(id);
                    if (i != 0) e_idx = i;
                    else begin
                        j = m_used(FIRST);
                        if (j != 0) begin m_cur = j + 1; e_id = m_map[j]; end
                        else begin m_cur = FIRST; e_id = ONES; end
                        e_st = 5;
                    end
                end
            end
            6: begin
                if (id == 0 || id == ONES) e_st = 3;
                else begin
                    i = (m_cnt != 0) ? m_find(id) : 0;
                    if (i != 0) e_idx = i;
                    else begin
                        j = m_find(0);
                        if (j != 0) begin m_map[j] = id; m_cnt++; e_idx = j; end
                        else e_st = 1;
                    end
                end
            end
            default: e_st = 3;
        endcase
    endtask

    // Issue one request, wait for its response, compare with the model.
    task automatic run_op(input int op, input logic [63:0] id, output int lat);
        int e_idx, e_st;
        logic [63:0] e_id;
        bit c_id;
        string tag;
        case (op)
            0: tag = "R2 lookup";
            1: tag = "R4 free";
            2: tag = "R6 clear";
            3: tag = "R7 next";
            4: tag = "R8 restart-next";
            5: tag = "R9/R10 read";
            6: tag = "R5 insert";
            default: tag = "R11 undefined op";
        endcase
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_id = id;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done) begin @(negedge clk); lat++; end
        model(op, id, e_idx, e_id, e_st, c_id);
        chk({tag, " idx"}, 64'(rsp_idx), 64'(e_idx));
        chk({tag, " status"}, 64'(rsp_status), 64'(e_st));
        if (c_id) chk({tag, " id"}, rsp_id, e_id);
        chk({tag, " count"}, 64'(rec_count), 64'(m_cnt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int lat, op, r;
        logic [63:0] id;
        void'($urandom(32'd2468));
        for (int i = 0; i < LAST; i++) m_map[i] = 0;
        m_cnt = 0; m_cur = FIRST;
        repeat (4) @(negedge clk);
        // R1: ready held low while directory is being cleared
        chk("R1 ready in reset", 64'(req_ready), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready during clear sweep", 64'(req_ready), 64'd0);
        while (!req_ready) @(negedge clk);
        chk("R1 count after reset", 64'(rec_count), 64'd0);
        chk("R1 done after reset", 64'(rsp_done), 64'd0);

        run_op(3, 0, lat);              // R7 empty store gives all ones
        run_op(5, 64'h55, lat);         // R9 empty store status 0x04
        run_op(0, 0, lat);              // R2 identifier 0
        run_op(6, 64'h11, lat);         // R5 first insert to slot 1
        run_op(0, 64'h99, lat);         // R3 miss with count 1
        chk("R3 early-stop latency", 64'(lat <= 8), 64'd1);
        run_op(0, 64'h11, lat);         // R2 hit
        run_op(6, 0, lat);              // R5 invalid id
        run_op(5, ONES, lat);           // R9 all-ones read
        run_op(7, 64'h11, lat);         // R11 undefined code
        for (int i = 0; i < 14; i++) run_op(6, 64'h100 + 64'(i), lat);
        run_op(6, 64'h200, lat);        // R5 full store
        run_op(1, 0, lat);              // R4 full store
        run_op(6, 64'h105, lat);        // R5 overwrite keeps slot
        run_op(2, 64'h105, lat);        // R6 clear present
        run_op(1, 0, lat);              // R4 reuse cleared slot
        run_op(0, 64'h105, lat);        // R6 cleared entry gone
        run_op(2, 64'h105, lat);        // R6 clear absent
        run_op(2, ONES, lat);           // R6 invalid
        for (int i = 0; i < 17; i++) run_op(3, 0, lat);  // R7 walk and wrap
        run_op(3, 0, lat);
        run_op(4, 0, lat);              // R8 restart
        run_op(5, 0, lat);              // R9 read of id 0
        run_op(5, 64'h777, lat);        // R10 read miss
        run_op(3, 0, lat);              // R10 iteration resumed after first

        for (int k = 0; k < 400; k++) begin
            r = $urandom % 10;
            case (r)
                0, 1, 2: op = 6;
                3, 9:    op = 2;
                4:       op = 0;
                5:       op = 3;
                6:       op = 4;
                7:       op = 5;
                default: op = 1;
            endcase
            r = $urandom % 24;
            if (r == 0) id = 0;
            else if (r == 1) id = ONES;
            else id = 64'hA5A5_0000_0000_0000 | 64'(r);
            run_op(op, id, lat);
        end

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule